// File: doc/BRIEF.md
# Automatic RS485 Driver-Enable Controller

This block steers the driver enable of an RS485 transceiver for a UART that sends in half duplex. It watches the transmit queue (holding register or FIFO) and the transmit shift register, and drives the RTS# line that enables the line driver. When automatic direction control is on, RTS# goes high as soon as a byte is queued. It stays high across back-to-back characters, and returns low only after the final stop bit of the last character has left the shifter with nothing left in the queue.

The shifter must not start a character until the driver has been enabled for at least one full bit time. A ready output, `load_ok`, gates the shifter. It asserts only after a programmable number of bit-rate ticks has been counted with RTS# high. The block also chooses what raises the transmit-empty interrupt. In automatic mode, the interrupt waits until the shifter is idle as well as the queue being empty. In normal mode, it fires on an empty queue alone, even while the shifter is still busy.

Automatic mode is on when the register enable bit is set, whatever the external enable pin says. When the register bit is clear, the pin decides. Bit serialization and baud generation belong to the surrounding UART: this block only receives a bit-rate tick and the shifter status strobes.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `rts_n` is 0 (driver off) and `tx_irq` is 0.
- R2: Automatic mode is active when `reg_auto_en` is 1 regardless of `pin_auto_en`, and also when only `pin_auto_en` is 1; it is inactive when both are 0.
- R3: In automatic mode with `rts_n` low, a cycle with `wr_stb` high makes `rts_n` 1 from the next cycle on.
- R4: After `rts_n` rises, `load_ok` stays 0 until GUARD_BITS+1 cycles with `bit_tick` high have been seen with `rts_n` high (default GUARD_BITS=1, so 2 ticks). It then becomes 1 the cycle after the last of those ticks; in automatic mode `load_ok` is never 1 while `rts_n` is 0.
- R5: In automatic mode `rts_n` stays 1 when `stop_done` arrives while `fifo_empty` is 0, or in the same cycle as `wr_stb`.
- R6: In automatic mode, with `load_ok` high, a cycle with `stop_done`=1, `fifo_empty`=1 and `wr_stb`=0 makes `rts_n` 0 from the next cycle.
- R7: In automatic mode `tx_irq` equals, one cycle later, `fifo_empty` AND NOT `tsr_busy`.
- R8: In normal mode `tx_irq` equals, one cycle later, `fifo_empty`, independent of `tsr_busy`.
- R9: In normal mode `rts_n` stays 0 even when `wr_stb` pulses, and `load_ok` is 1.
- R10: If automatic mode is switched off while the driver is enabled, `rts_n` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_auto_en | input | 1 | Register enable for automatic direction control (dominant) |
| pin_auto_en | input | 1 | External enable for automatic control, used when the register bit is 0 |
| wr_stb | input | 1 | One-cycle strobe: a byte was written to the holding register or FIFO |
| fifo_empty | input | 1 | Transmit holding register / FIFO is empty |
| tsr_busy | input | 1 | Transmit shift register is shifting a character |
| stop_done | input | 1 | One-cycle strobe: the stop bit of the character in the shifter has finished |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rts_n | output | 1 | Driver enable line, 1 = driver on |
| load_ok | output | 1 | Shifter may load the next character |
| tx_irq | output | 1 | Transmit-empty interrupt request (level) |

## Verification
The assertions check on every cycle that the driver rises on a queued byte and holds while the queue still has data. They also check that it drops after the last stop bit with an empty queue, and at once when automatic mode is turned off. Further per-cycle checks: `load_ok` never asserts with the driver off or without the guard count completing, and the interrupt never asserts in automatic mode while the shifter was busy. The exact guard length in ticks, the dominance of the register bit over the pin, and the full interrupt level in both modes are shown by the bench scenarios, which compare all outputs each cycle against an independent reference model under random traffic.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GUARD  = 2'd1,
    PH_ACTIVE = 2'd2
  } dir_phase_e;

  // Register bit wins; with it clear the pin selects.
  function automatic logic auto_select(input logic reg_en, input logic pin_en);
    return reg_en ? 1'b1 : pin_en;
  endfunction

  // Interrupt source: shifter-empty in automatic mode, queue-empty otherwise.
  function automatic logic irq_source(input logic auto_on, input logic q_empty,
                                      input logic shift_busy);
    return auto_on ? (q_empty & ~shift_busy) : q_empty;
  endfunction

  // Driver may be released: last stop bit done, nothing queued, no new byte.
  function automatic logic release_ok(input logic stop_evt, input logic q_empty,
                                      input logic wr_evt);
    return stop_evt & q_empty & ~wr_evt;
  endfunction

endpackage

// File: rtl/rs485_guard_timer.sv
module rs485_guard_timer #(
  parameter int GUARD_BITS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_tick,
  output logic done
);
  localparam int NEED = GUARD_BITS + 1;
  localparam int CW   = $clog2(NEED + 1);

  logic [CW-1:0] cnt_q;

  assign done = run & bit_tick & (cnt_q == CW'(NEED - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || done)   cnt_q <= '0;
    else if (bit_tick)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_mode,
  input  logic       wr_stb,
  input  logic       stop_done,
  input  logic       fifo_empty,
  input  logic       guard_done,
  output dir_phase_e phase,
  output logic       guard_run,
  output logic       release_evt
);
  dir_phase_e phase_q, phase_d;

  assign phase       = phase_q;
  assign guard_run   = (phase_q == PH_GUARD);
  assign release_evt = (phase_q == PH_ACTIVE) & release_ok(stop_done, fifo_empty, wr_stb);

  always_comb begin
    phase_d = phase_q;
    if (!auto_mode) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:   if (wr_stb)      phase_d = PH_GUARD;
        PH_GUARD:  if (guard_done)  phase_d = PH_ACTIVE;
        PH_ACTIVE: if (release_evt) phase_d = PH_IDLE;
        default:                    phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/rs485_irq_sel.sv
module rs485_irq_sel
  import rs485_dir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_mode,
  input  logic fifo_empty,
  input  logic tsr_busy,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_source(auto_mode, fifo_empty, tsr_busy);
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int GUARD_BITS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_auto_en,
  input  logic pin_auto_en,
  input  logic wr_stb,
  input  logic fifo_empty,
  input  logic tsr_busy,
  input  logic stop_done,
  input  logic bit_tick,
  output logic rts_n,
  output logic load_ok,
  output logic tx_irq
);
  // Named internal events, visible to the bound checker.
  logic       auto_mode;
  logic       guard_run;
  logic       guard_done;
  logic       release_evt;
  dir_phase_e phase;

  assign auto_mode = auto_select(reg_auto_en, pin_auto_en);

  rs485_guard_timer #(.GUARD_BITS(GUARD_BITS)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (guard_run),
    .bit_tick (bit_tick),
    .done     (guard_done)
  );

  rs485_dir_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_mode   (auto_mode),
    .wr_stb      (wr_stb),
    .stop_done   (stop_done),
    .fifo_empty  (fifo_empty),
    .guard_done  (guard_done),
    .phase       (phase),
    .guard_run   (guard_run),
    .release_evt (release_evt)
  );

  rs485_irq_sel u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_mode  (auto_mode),
    .fifo_empty (fifo_empty),
    .tsr_busy   (tsr_busy),
    .irq        (tx_irq)
  );

  assign rts_n   = (phase != PH_IDLE);
  assign load_ok = auto_mode ? (phase == PH_ACTIVE) : 1'b1;
endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_auto_en,
  input logic pin_auto_en,
  input logic wr_stb,
  input logic fifo_empty,
  input logic tsr_busy,
  input logic stop_done,
  input logic rts_n,
  input logic load_ok,
  input logic tx_irq,
  input logic auto_mode,
  input logic guard_done,
  input logic release_evt
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!rts_n && !tx_irq); // R1
  end

  AST_REG_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_auto_en && !pin_auto_en && !rts_n && wr_stb |=> rts_n); // R2

  AST_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && !rts_n && wr_stb |=> rts_n); // R3

  AST_LOAD_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && load_ok |-> rts_n); // R4

  AST_LOAD_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && $rose(load_ok) |-> $past(guard_done)); // R4

  AST_HOLD_WHILE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && rts_n && !fifo_empty |=> rts_n); // R5

  AST_FALL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && load_ok && stop_done && fifo_empty && !wr_stb |=> !rts_n); // R6

  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |-> fifo_empty && stop_done); // R6

  AST_IRQ_WAITS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && tsr_busy |=> !tx_irq); // R7

  AST_IRQ_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode && fifo_empty |=> tx_irq); // R8

  AST_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> !rts_n); // R10
endmodule

bind rs485_dir_ctrl rs485_dir_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_auto_en (reg_auto_en),
  .pin_auto_en (pin_auto_en),
  .wr_stb      (wr_stb),
  .fifo_empty  (fifo_empty),
  .tsr_busy    (tsr_busy),
  .stop_done   (stop_done),
  .rts_n       (rts_n),
  .load_ok     (load_ok),
  .tx_irq      (tx_irq),
  .auto_mode   (auto_mode),
  .guard_done  (guard_done),
  .release_evt (release_evt)
);

// File: tb/sim_rs485_dir_ctrl.sv
module sim_rs485_dir_ctrl;
  localparam int GB   = 1;
  localparam int NEED = GB + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_auto_en = 0, pin_auto_en = 0, wr_stb = 0, fifo_empty = 1;
  logic tsr_busy = 0, stop_done = 0, bit_tick = 0;
  logic rts_n, load_ok, tx_irq;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  rs485_dir_ctrl #(.GUARD_BITS(GB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_auto_en(reg_auto_en), .pin_auto_en(pin_auto_en),
    .wr_stb(wr_stb), .fifo_empty(fifo_empty), .tsr_busy(tsr_busy),
    .stop_done(stop_done), .bit_tick(bit_tick),
    .rts_n(rts_n), .load_ok(load_ok), .tx_irq(tx_irq));

  // Reference model written from the requirements.
  int m_phase = 0;   // 0 off, 1 waiting guard, 2 shifter allowed
  int m_ticks = 0;
  bit m_irq   = 0;

  function automatic bit ref_auto(bit r, bit p);
    if (r) return 1'b1;         // R2: register bit dominant
    return p;
  endfunction

  function automatic bit ref_irq(bit a, bit fe, bit busy);
    if (a) return fe && !busy;  // R7
    return fe;                  // R8
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_ticks <= 0; m_irq <= 0;
    end else begin
      m_irq <= ref_irq(ref_auto(reg_auto_en, pin_auto_en), fifo_empty, tsr_busy);
      if (!ref_auto(reg_auto_en, pin_auto_en)) begin
        m_phase <= 0; m_ticks <= 0;
      end else if (m_phase == 0) begin
        if (wr_stb) begin m_phase <= 1; m_ticks <= 0; end
      end else if (m_phase == 1) begin
        if (bit_tick) begin
          if (m_ticks + 1 == NEED) begin m_phase <= 2; m_ticks <= 0; end
          else m_ticks <= m_ticks + 1;
        end
      end else if (stop_done && fifo_empty && !wr_stb) begin
        m_phase <= 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " rts_n"}, rts_n, m_phase != 0);
    chk({tag, " load_ok"}, load_ok,
        ref_auto(reg_auto_en, pin_auto_en) ? (m_phase == 2) : 1'b1);
    chk({tag, " tx_irq"}, tx_irq, m_irq);
  endtask

  // Advance one clock; inputs change at the falling edge only.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_stb = 0; stop_done = 0; bit_tick = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0485));
    repeat (3) @(negedge clk);
    chk("R1 rts_n in reset", rts_n, 1'b0);
    chk("R1 tx_irq in reset", tx_irq, 1'b0);
    rst_n = 1;
    step();
    chk("R1 rts_n after reset", rts_n, 1'b0);

    // R2/R3: register bit alone enables auto mode
    reg_auto_en = 1; pin_auto_en = 0; fifo_empty = 0; wr_stb = 1;
    step();
    chk("R3 rts_n rises after write", rts_n, 1'b1);
    chk("R4 load_ok low before guard", load_ok, 1'b0);
    // R4: two ticks required by default
    bit_tick = 1; step();
    chk("R4 load_ok low after one tick", load_ok, 1'b0);
    step();
    chk("R4 no tick no load_ok", load_ok, 1'b0);
    bit_tick = 1; step();
    chk("R4 load_ok after guard ticks", load_ok, 1'b1);
    tsr_busy = 1;
    // R5: stop with queue not empty keeps driver
    stop_done = 1; fifo_empty = 0; step();
    chk("R5 hold with queued data", rts_n, 1'b1);
    fifo_empty = 1; stop_done = 1; wr_stb = 1; step();
    chk("R5 hold on simultaneous write", rts_n, 1'b1);
    // R7: shifter still busy blocks interrupt
    chk("R7 irq blocked while shifting", tx_irq, 1'b0);
    tsr_busy = 0; step();
    chk("R7 irq on shifter empty", tx_irq, 1'b1);
    // R6: last stop bit with empty queue drops driver
    stop_done = 1; step();
    chk("R6 rts_n falls after last stop", rts_n, 1'b0);
    chk("R6 load_ok falls with driver", load_ok, 1'b0);

    // R2: pin alone enables when register bit is clear
    reg_auto_en = 0; pin_auto_en = 1; wr_stb = 1; fifo_empty = 0; step();
    chk("R2 pin enables auto", rts_n, 1'b1);
    // R10: disable mid-transfer
    pin_auto_en = 0; step();
    chk("R10 drop on disable", rts_n, 1'b0);
    // R8/R9: normal mode
    fifo_empty = 1; tsr_busy = 1; wr_stb = 1; step();
    chk("R8 irq on queue empty while shifting", tx_irq, 1'b1);
    chk("R9 rts_n stays low in normal mode", rts_n, 1'b0);
    chk("R9 load_ok high in normal mode", load_ok, 1'b1);
    fifo_empty = 0; step();
    chk("R8 irq clears with queued data", tx_irq, 1'b0);
    // R2: both enables low gives normal mode
    chk_model("R2 both off");

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 100) < 3) reg_auto_en = $urandom % 2;
      if (($urandom % 100) < 3) pin_auto_en = $urandom % 2;
      if (i % 500 == 0) reg_auto_en = 1;
      wr_stb     = ($urandom % 100) < 20;
      stop_done  = ($urandom % 100) < 15;
      bit_tick   = ($urandom % 100) < 30;
      fifo_empty = ($urandom % 100) < 55;
      tsr_busy   = ($urandom % 100) < 50;
      step();
      chk_model("R3/R4/R5/R6/R7/R8/R9/R10 random");
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule